// File: doc/BRIEF.md
# Asynchronous Host SDRAM Strobe Bridge

This block sits between a slow controller running on its own oscillator and an SDRAM running on a separate, unrelated memory clock. The controller signals its intent through plain levels held for many of its own cycles. The bridge samples every one of those levels in the memory clock domain. It turns each new request into a strobe that lasts exactly one memory clock, so the memory can never register one request twice.

Chip-select normally comes out as a single-cycle low strobe. A separate hold level keeps it low without a break. The memory needs this, because it takes its command on the edge where clock-enable is first seen low, so chip-select must be valid on both sides of that edge. Clock-enable is high by default. While a park level is high it is held low, and each step request then raises it for one memory clock, which moves a suspended burst along by one column. The address, command and byte-mask lines go through a register chain as deep as the strobe path, so they reach the memory in the same cycle as the strobe they belong to.

Top module: `sdb_strobe_bridge`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is sampled high, `sd_cs_n`=1, `sd_cke`=1, `sd_cmd`=3'b111 (bit 2 row strobe, bit 1 column strobe, bit 0 write enable, all high meaning no-operation), `sd_addr`=0 and `sd_dqm`=0.
- R2: Each rising edge of `host_cs_req` gives exactly one memory clock cycle with `sd_cs_n` low. This holds when the level stays high for at least 3 memory clocks and low for at least 3 memory clocks between edges.
- R3: A level change applied between two memory clock edges shows up on the outputs just after the third following rising edge: the first edge samples it and two more edges follow.
- R4: A `host_cs_req` held high for a long time gives no strobe after the first, and its falling edge gives no strobe.
- R5: While `host_cs_hold` is high, `sd_cs_n` stays low without a break, with the R3 latency. Whatever `host_cs_req` does during that time, the number of low cycles equals the number of clocks for which the hold was high.
- R6: While `host_cke_park` is high, `sd_cke` is low (R3 latency). Each rising edge of `host_cke_step` in that time drives `sd_cke` high for exactly one memory clock.
- R7: Edges on `host_cke_step` while `host_cke_park` is low leave `sd_cke` high.
- R8: `sd_addr`, `sd_cmd` and `sd_dqm` follow `host_addr`, `host_cmd` and `host_dqm` with the R3 latency, so the strobe cycle carries the host values present when the request was raised.
- R9: A run of 256 step requests under park, with a host pace chosen at random, gives exactly 256 single-cycle clock-enable strobes, one for each column of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_req | input | 1 | Asynchronous chip-select request level |
| host_cs_hold | input | 1 | Asynchronous level that holds chip-select asserted |
| host_cke_park | input | 1 | Asynchronous level that holds clock-enable low |
| host_cke_step | input | 1 | Asynchronous level whose rising edge gives one clock-enable strobe |
| host_addr | input | ADDR_W | Host address lines |
| host_cmd | input | 3 | Host command lines {row strobe, column strobe, write enable}, active-low |
| host_dqm | input | DQM_W | Host byte-mask lines |
| sd_cs_n | output | 1 | Chip-select to the memory, active-low |
| sd_cke | output | 1 | Clock-enable to the memory |
| sd_addr | output | ADDR_W | Registered address |
| sd_cmd | output | 3 | Registered command |
| sd_dqm | output | DQM_W | Registered byte mask |

## Verification
Pulse trains on the chip-select and step requests use high and low widths from just above the minimum up to many times it. The host period is drawn at random for each train, so edges fall at arbitrary phases of the memory clock. Counting strobe cycles per train tells a correct one-shot apart from one that widens, repeats or drops a strobe. A 256-step burst under park stands in for walking a full row of columns. Directed cases pin the exact latency and bus alignment, separate the continuous hold from the one-shot, and show that a held request, a falling edge, or a step without park gives no strobe.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    // Command lines to the memory, all active-low
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdb_cmd_t;

    localparam sdb_cmd_t CMD_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_ADDR_W      = 13;
    localparam int DEF_DQM_W       = 2;

    // Register count from an asynchronous input to a bridge output
    function automatic int path_depth(input int sync_stages);
        return sync_stages + 1;
    endfunction

endpackage

// File: rtl/sdb_sync.sv
module sdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sdb_edge.sv
module sdb_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign pulse = level & ~prev;

    // R2
    pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/sdb_pipe.sv
module sdb_pipe #(
    parameter int           W       = 8,
    parameter int           DEPTH   = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stg
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/sdb_strobe_bridge.sv
module sdb_strobe_bridge
    import sdb_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DQM_W       = DEF_DQM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_req,
    input  logic              host_cs_hold,
    input  logic              host_cke_park,
    input  logic              host_cke_step,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [2:0]        host_cmd,
    input  logic [DQM_W-1:0]  host_dqm,
    output logic              sd_cs_n,
    output logic              sd_cke,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [2:0]        sd_cmd,
    output logic [DQM_W-1:0]  sd_dqm
);
    localparam int N_LVL  = 4;
    localparam int BUS_W  = ADDR_W + $bits(sdb_cmd_t) + DQM_W;
    localparam int DEPTH  = path_depth(SYNC_STAGES);
    localparam logic [BUS_W-1:0] BUS_RST = {{ADDR_W{1'b0}}, CMD_NOP, {DQM_W{1'b0}}};

    // Level index map: 0 cs request, 1 cs hold, 2 park, 3 step
    logic [N_LVL-1:0] lvl_async, lvl_sync;
    assign lvl_async = {host_cke_step, host_cke_park, host_cs_hold, host_cs_req};

    for (genvar g = 0; g < N_LVL; g++) begin : g_sync
        sdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .async_in(lvl_async[g]), .sync_out(lvl_sync[g])
        );
    end

    logic cs_pulse, step_pulse;

    sdb_edge u_cs_edge   (.clk(clk), .rst(rst), .level(lvl_sync[0]), .pulse(cs_pulse));
    sdb_edge u_step_edge (.clk(clk), .rst(rst), .level(lvl_sync[3]), .pulse(step_pulse));

    // Output strobes straight from flops
    logic hold_q, park_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_cs_n <= 1'b1;
            sd_cke  <= 1'b1;
            hold_q  <= 1'b0;
            park_q  <= 1'b0;
        end else begin
            sd_cs_n <= ~(cs_pulse | lvl_sync[1]);
            sd_cke  <= ~lvl_sync[2] | step_pulse;
            hold_q  <= lvl_sync[1];
            park_q  <= lvl_sync[2];
        end
    end

    // Bus delayed to line up with the strobes
    logic [BUS_W-1:0] bus_in, bus_out;
    assign bus_in = {host_addr, host_cmd, host_dqm};

    sdb_pipe #(.W(BUS_W), .DEPTH(DEPTH), .RST_VAL(BUS_RST)) u_bus (
        .clk(clk), .rst(rst), .din(bus_in), .dout(bus_out)
    );

    assign sd_addr = bus_out[BUS_W-1 -: ADDR_W];
    assign sd_cmd  = bus_out[DQM_W +: 3];
    assign sd_dqm  = bus_out[DQM_W-1:0];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sd_cs_n && sd_cke && sd_cmd == 3'b111));

    // R2
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        (!sd_cs_n && !hold_q) |=> (sd_cs_n || hold_q));

    // R5
    hold_cs_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> !sd_cs_n);

    // R6
    cke_single_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_cke && park_q) |=> (!sd_cke || !park_q));
endmodule

// File: tb/sdb_strobe_bridge_bench.sv
`timescale 1ns/1ps
module sdb_strobe_bridge_bench;
    localparam int ADDR_W = 13;
    localparam int DQM_W  = 2;
    localparam int NT     = 6;
    // Train table: target (0 cs request, 1 step under park), high/low widths in host cycles, edges
    localparam int T_SEL [NT] = '{0, 0, 0, 1, 1, 1};
    localparam int T_HI  [NT] = '{3, 8, 20, 3, 5, 12};
    localparam int T_LO  [NT] = '{3, 4, 3, 3, 9, 3};
    localparam int T_N   [NT] = '{5, 3, 2, 6, 4, 3};

    logic clk = 0, rst = 1;
    logic host_cs_req = 0, host_cs_hold = 0, host_cke_park = 0, host_cke_step = 0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [2:0] host_cmd = 3'b111;
    logic [DQM_W-1:0] host_dqm = '0;
    logic sd_cs_n, sd_cke;
    logic [ADDR_W-1:0] sd_addr;
    logic [2:0] sd_cmd;
    logic [DQM_W-1:0] sd_dqm;

    int checks = 0, failures = 0;
    int cs_lo_cnt = 0, cke_hi_cnt = 0, cke_lo_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdb_strobe_bridge #(.ADDR_W(ADDR_W), .DQM_W(DQM_W)) u_sdb_strobe_bridge (
        .clk(clk), .rst(rst),
        .host_cs_req(host_cs_req), .host_cs_hold(host_cs_hold),
        .host_cke_park(host_cke_park), .host_cke_step(host_cke_step),
        .host_addr(host_addr), .host_cmd(host_cmd), .host_dqm(host_dqm),
        .sd_cs_n(sd_cs_n), .sd_cke(sd_cke), .sd_addr(sd_addr),
        .sd_cmd(sd_cmd), .sd_dqm(sd_dqm)
    );

    // Memory-side monitor: one sample per clock, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!sd_cs_n) cs_lo_cnt++;
            if (sd_cke) cke_hi_cnt++;
            else        cke_lo_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic train(input int sel, input int hi, input int lo, input int n, input int hp);
        for (int i = 0; i < n; i++) begin
            if (sel == 0) host_cs_req = 1; else host_cke_step = 1;
            #(hi * hp);
            if (sel == 0) host_cs_req = 0; else host_cke_step = 0;
            #(lo * hp);
        end
    endtask

    initial begin
        int base, hp;
        // R1 reset state
        clks(5);
        chk("R1 cs_n", sd_cs_n, 1);
        chk("R1 cke", sd_cke, 1);
        chk("R1 cmd", sd_cmd, 3'b111);
        chk("R1 addr/dqm", {sd_addr, sd_dqm}, 0);
        rst = 0;
        clks(5);

        // Table of pulse trains at random host pace (R2, R6)
        for (int t = 0; t < NT; t++) begin
            hp = $urandom_range(17, 5);
            if (T_SEL[t] == 1) begin host_cke_park = 1; clks(8); end
            base = (T_SEL[t] == 0) ? cs_lo_cnt : cke_hi_cnt;
            train(T_SEL[t], T_HI[t], T_LO[t], T_N[t], hp);
            clks(8);
            if (T_SEL[t] == 0) chk("R2 cs strobe count", cs_lo_cnt - base, T_N[t]);
            else               chk("R6 cke strobe count", cke_hi_cnt - base, T_N[t]);
            host_cke_park = 0;
            clks(8);
        end

        // R3 latency and R8 bus alignment
        base = cs_lo_cnt;
        @(posedge clk); #1;
        host_addr = 13'h1A5; host_cmd = 3'b010; host_dqm = 2'b01; host_cs_req = 1;
        clks(2);
        chk("R3 no strobe before third edge", sd_cs_n, 1);
        chk("R8 bus not yet updated", sd_addr, 0);
        clks(1);
        chk("R3 strobe after third edge", sd_cs_n, 0);
        chk("R8 bus with strobe", {sd_addr, sd_cmd, sd_dqm}, {13'h1A5, 3'b010, 2'b01});
        clks(1);
        chk("R2 strobe one cycle wide", sd_cs_n, 1);

        // R4 held request and falling edge
        clks(40);
        chk("R4 held request single strobe", cs_lo_cnt - base, 1);
        host_cs_req = 0;
        clks(15);
        chk("R4 falling edge no strobe", cs_lo_cnt - base, 1);

        // R5 hold keeps chip-select low, request inside is absorbed
        base = cs_lo_cnt;
        @(posedge clk); #1;
        host_cs_hold = 1;
        clks(5);
        host_cs_req = 1;
        clks(5);
        chk("R5 cs low during hold", sd_cs_n, 0);
        clks(10);
        host_cs_hold = 0;
        clks(10);
        chk("R5 hold low cycle count", cs_lo_cnt - base, 20);
        host_cs_req = 0;
        clks(8);

        // R7 steps without park
        base = cke_lo_cnt;
        train(1, 4, 4, 3, 9);
        clks(8);
        chk("R7 step without park", cke_lo_cnt - base, 0);

        // R6 park drives clock-enable low
        host_cke_park = 1;
        clks(4);
        chk("R6 cke low under park", sd_cke, 0);

        // R9 full row of column steps
        base = cke_hi_cnt;
        hp = $urandom_range(13, 5);
        train(1, 3, 3, 256, hp);
        clks(8);
        chk("R9 256 column strobes", cke_hi_cnt - base, 256);
        host_cke_park = 0;
        clks(8);
        chk("R6 cke high after park", sd_cke, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule